// File: doc/BRIEF.md
# Sector Buffer with Identity Header

This block is the byte store that sits between a disk controller's host data port and its media engine. It holds one sector's payload behind a four-byte identity header. The host reaches it through a single auto-advancing index: every accepted data-port read or write touches the byte at the index and then moves the index on by one. A separate rewind strobe, the sector-ID port write, returns the index to zero without storing anything.

When a read or write command begins (`cmd_start`), the header slots are loaded with the current cylinder (high byte first), head and sector, and the host index is cleared. The host can then read the identity back or write payload after it. The media engine runs its own sequencer. It transfers exactly one configured sector length, one byte per cycle, starting at byte 4, in either direction, and it marks the end with a one-cycle done pulse.

Top module: `sector_id_buffer`

## Requirements
- R1: After reset `host_idx` is 0, and `med_beat` and `med_done` are 0.
- R2: A `cmd_start` cycle writes byte 0 = `cyl[15:8]`, byte 1 = `cyl[7:0]`, byte 2 = `head`, byte 3 = `sect`, and `host_idx` is 0 from the next cycle on.
- R3: `host_rdata` shows the byte at `host_idx` in the same cycle. An accepted `host_wr` or `host_rd` cycle raises `host_idx` by exactly 1, and `host_wr` stores `host_wdata` at the old index.
- R4: An `id_rewind` cycle makes `host_idx` 0 on the next cycle and stores no data. Priority is `cmd_start`, then `id_rewind`, then host access. An access in the same cycle as either clear is ignored.
- R5: With payload bytes P = 1024, `host_idx` saturates at P+4 = 1028. Accesses there leave the index and the store unchanged, and `host_rdata` reads 0.
- R6: After an idle-cycle `med_start`, `med_beat` is high for exactly 128 << `med_sel` consecutive cycles, starting on the next cycle. Beat k addresses byte 4+k. `med_done` pulses for one cycle on the cycle after the last beat.
- R7: With `med_dir` = 1 latched at start, beat k stores `med_wdata` at byte 4+k. With `med_dir` = 0, `med_rdata` presents byte 4+k during beat k.
- R8: `med_start` during a transfer is ignored: the beat count, direction and addresses of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Read/write command start: load header, clear index |
| cyl | input | 16 | Current cylinder |
| head | input | 8 | Current head |
| sect | input | 8 | Current sector |
| id_rewind | input | 1 | Sector-ID port write: rewind host index |
| host_wr | input | 1 | Host data-port write |
| host_rd | input | 1 | Host data-port read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the host index |
| host_idx | output | 11 | Host index |
| med_start | input | 1 | Start a media transfer |
| med_dir | input | 1 | 1: media to buffer, 0: buffer to media |
| med_sel | input | 2 | Sector length select, 128 << sel bytes |
| med_wdata | input | 8 | Media byte into buffer |
| med_rdata | output | 8 | Buffer byte to media |
| med_beat | output | 1 | A payload byte moves this cycle |
| med_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
`host_rdata` is combinational, so it is sampled in the same half-cycle in which the read is issued. A stored write or an index change appears one edge later, and the header load and index clear are also due one edge after `cmd_start`. The first media beat comes one edge after `med_start`, and `med_done` shows in the half-cycle right after the last beat. Each task drives on the falling edge and samples on the next falling edge, so every result is read at exactly the cycle in which it falls due, and beats are counted one by one against 128 << `med_sel`.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int HDR_BYTES = 4;

  typedef enum logic {
    BUF_TO_MED = 1'b0,
    MED_TO_BUF = 1'b1
  } med_dir_e;

  // payload length for a select code
  function automatic int unsigned sect_bytes(input logic [1:0] sel, input int unsigned min_log2);
    return 32'd1 << (min_log2 + 32'(sel));
  endfunction

  // identity header slot contents
  function automatic logic [7:0] hdr_byte(input int slot, input logic [15:0] c,
                                          input logic [7:0] h, input logic [7:0] s);
    case (slot)
      0:       return c[15:8];
      1:       return c[7:0];
      2:       return h;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/sb_host_index.sv
module sb_host_index #(
  parameter int DEPTH = 1028,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_cmd,
  input  logic             clr_id,
  input  logic             access,
  output logic [IDX_W-1:0] idx,
  output logic             accept
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

  assign accept = access && !clr_cmd && !clr_id && (idx < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                 idx <= '0;
    else if (clr_cmd || clr_id) idx <= '0;
    else if (accept)            idx <= idx + 1'b1;
  end
endmodule

// File: rtl/sb_media.sv
module sb_media #(
  parameter int IDX_W    = 11,
  parameter int MIN_LOG2 = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       sel,
  input  logic             dir_in,
  output logic             beat,
  output logic [IDX_W-1:0] ptr,
  output logic             dir_q,
  output logic             done
);
  import sbuf_pkg::*;

  logic             busy;
  logic [IDX_W-1:0] last_q;

  assign beat = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ptr    <= '0;
      last_q <= '0;
      dir_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy   <= 1'b1;
        ptr    <= IDX_W'(HDR_BYTES);
        last_q <= IDX_W'(HDR_BYTES + sect_bytes(sel, MIN_LOG2) - 1);
        dir_q  <= dir_in;
      end else if (busy) begin
        ptr <= ptr + 1'b1;
        if (ptr == last_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DEPTH = 1028,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             hdr_load,
  input  logic [15:0]      cyl,
  input  logic [7:0]       head,
  input  logic [7:0]       sect,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             med_we,
  input  logic [IDX_W-1:0] med_addr,
  input  logic [7:0]       med_wdata,
  output logic [7:0]       med_rdata
);
  import sbuf_pkg::*;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (med_we && med_addr < IDX_W'(DEPTH)) mem[med_addr] <= med_wdata;
    if (host_we) mem[host_addr] <= host_wdata;
    if (hdr_load)
      for (int s = 0; s < HDR_BYTES; s++) mem[s] <= hdr_byte(s, cyl, head, sect);
  end

  assign host_rdata = (host_addr < IDX_W'(DEPTH)) ? mem[host_addr] : 8'h00;
  assign med_rdata  = (med_addr  < IDX_W'(DEPTH)) ? mem[med_addr]  : 8'h00;
endmodule

// File: rtl/sector_id_buffer.sv
module sector_id_buffer #(
  parameter int MIN_LOG2 = 7,
  parameter int MAX_SEL  = 3,
  localparam int PAYLOAD = 1 << (MIN_LOG2 + MAX_SEL),
  localparam int DEPTH   = PAYLOAD + sbuf_pkg::HDR_BYTES,
  localparam int IDX_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [15:0]      cyl,
  input  logic [7:0]       head,
  input  logic [7:0]       sect,
  input  logic             id_rewind,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic [IDX_W-1:0] host_idx,
  input  logic             med_start,
  input  logic             med_dir,
  input  logic [1:0]       med_sel,
  input  logic [7:0]       med_wdata,
  output logic [7:0]       med_rdata,
  output logic             med_beat,
  output logic             med_done
);
  import sbuf_pkg::*;

  logic             host_accept;
  logic [IDX_W-1:0] med_ptr;
  logic             med_dir_q;
  logic             med_we;

  sb_host_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr_cmd(cmd_start), .clr_id(id_rewind),
    .access(host_wr | host_rd), .idx(host_idx), .accept(host_accept)
  );

  sb_media #(.IDX_W(IDX_W), .MIN_LOG2(MIN_LOG2)) u_med (
    .clk(clk), .rst_n(rst_n), .start(med_start), .sel(med_sel), .dir_in(med_dir),
    .beat(med_beat), .ptr(med_ptr), .dir_q(med_dir_q), .done(med_done)
  );

  assign med_we = med_beat && (med_dir_q == MED_TO_BUF);

  sb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .hdr_load(cmd_start), .cyl(cyl), .head(head), .sect(sect),
    .host_we(host_accept && host_wr), .host_addr(host_idx), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .med_we(med_we), .med_addr(med_ptr), .med_wdata(med_wdata), .med_rdata(med_rdata)
  );
endmodule

// File: rtl/sector_id_buffer_chk.sv
module sector_id_buffer_chk #(
  parameter int MIN_LOG2 = 7,
  parameter int DEPTH    = 1028,
  parameter int IDX_W    = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             id_rewind,
  input logic             host_wr,
  input logic             host_rd,
  input logic [IDX_W-1:0] host_idx,
  input logic             med_start,
  input logic [1:0]       med_sel,
  input logic             med_beat,
  input logic             med_done
);
  // beat counter and captured length, checked against done
  int unsigned beats, want;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats <= 0;
      want  <= 0;
    end else if (!med_beat && med_start) begin
      beats <= 0;
      want  <= sbuf_pkg::sect_bytes(med_sel, MIN_LOG2);
    end else if (med_beat) begin
      beats <= beats + 1;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> host_idx == '0 && !med_done);
  p_cmd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n) cmd_start |=> host_idx == '0);
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr || host_rd) && !cmd_start && !id_rewind && host_idx < IDX_W'(DEPTH)
    |=> host_idx == $past(host_idx) + 1'b1);
  p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n) id_rewind |=> host_idx == '0);
  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) host_idx <= IDX_W'(DEPTH));
  p_hold_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_idx == IDX_W'(DEPTH) && !cmd_start && !id_rewind |=> $stable(host_idx));
  p_done_follows_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    med_done |-> !med_beat && $past(med_beat));
  p_done_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    med_done |-> beats == want);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    med_beat && !med_done |=> med_beat || med_done);
endmodule

bind sector_id_buffer sector_id_buffer_chk #(.MIN_LOG2(MIN_LOG2), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .id_rewind(id_rewind),
  .host_wr(host_wr), .host_rd(host_rd), .host_idx(host_idx),
  .med_start(med_start), .med_sel(med_sel), .med_beat(med_beat), .med_done(med_done)
);

// File: tb/sector_id_buffer_tb_top.sv
module sector_id_buffer_tb_top;
  localparam int DEPTH = 1028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, id_rewind = 0, host_wr = 0, host_rd = 0;
  logic med_start = 0, med_dir = 0;
  logic [1:0] med_sel = 0;
  logic [15:0] cyl = 0;
  logic [7:0] head = 0, sect = 0, host_wdata = 0, med_wdata = 0;
  logic [7:0] host_rdata, med_rdata;
  logic [10:0] host_idx;
  logic med_beat, med_done;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  sector_id_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cyl(cyl), .head(head), .sect(sect),
    .id_rewind(id_rewind), .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_idx(host_idx), .med_start(med_start), .med_dir(med_dir),
    .med_sel(med_sel), .med_wdata(med_wdata), .med_rdata(med_rdata), .med_beat(med_beat),
    .med_done(med_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((k * 7 + seed) & 8'hFF);
  endfunction

  task automatic cmd(input logic [15:0] c, input logic [7:0] h, input logic [7:0] s);
    cyl = c; head = h; sect = s; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic rewind();
    id_rewind = 1; @(negedge clk); id_rewind = 0;
  endtask

  task automatic hwrite(input logic [7:0] d);
    host_wdata = d; host_wr = 1; @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(output logic [7:0] d);
    d = host_rdata; host_rd = 1; @(negedge clk); host_rd = 0;
  endtask

  // one media transfer; a second start is tried at beat 10
  task automatic med_xfer(input logic dir, input logic [1:0] sel, input int seed, input string req);
    int k = 0;
    int len = 128 << sel;
    med_dir = dir; med_sel = sel; med_start = 1;
    @(negedge clk); med_start = 0;
    while (med_beat && k < 2000) begin
      if (dir) med_wdata = pat(seed, k);
      else     check({req, " R7 media read byte"}, med_rdata, pat(seed, k));
      med_start = (k == 10); med_sel = 2'd3; med_dir = ~dir;
      k++;
      @(negedge clk);
      med_start = 0;
    end
    check({req, " R6/R8 beat count"}, k, len);
    check("R6 done after last beat", med_done, 1);
    @(negedge clk);
    check("R6 done one cycle", med_done, 0);
  endtask

  task automatic t_reset();
    check("R1 idx", host_idx, 0);
    check("R1 beat", med_beat, 0);
    check("R1 done", med_done, 0);
  endtask

  task automatic t_header();
    logic [7:0] d;
    hwrite(8'h33);
    cmd(16'h0123, 8'h05, 8'h09);
    check("R2 idx cleared", host_idx, 0);
    hread(d); check("R2 cyl hi", d, 8'h01);
    hread(d); check("R2 cyl lo", d, 8'h23);
    hread(d); check("R2 head", d, 8'h05);
    hread(d); check("R2 sect", d, 8'h09);
    check("R3 idx after 4 reads", host_idx, 4);
  endtask

  task automatic t_rw_rewind();
    logic [7:0] d;
    cmd(16'hBEEF, 8'h02, 8'h11);
    for (int i = 0; i < 4; i++) hread(d);
    hwrite(8'hA1); hwrite(8'hB2); hwrite(8'hC3);
    check("R3 idx after writes", host_idx, 7);
    rewind();
    check("R4 rewind idx", host_idx, 0);
    hread(d); check("R4 rewind stores nothing", d, 8'hBE);
    // rewind with a simultaneous write: write ignored
    host_wdata = 8'h77; host_wr = 1; id_rewind = 1;
    @(negedge clk); host_wr = 0; id_rewind = 0;
    check("R4 priority idx", host_idx, 0);
    check("R4 priority no store", host_rdata, 8'hBE);
    // cmd_start beats rewind
    cyl = 16'h4455; head = 1; sect = 2; cmd_start = 1; id_rewind = 1;
    @(negedge clk); cmd_start = 0; id_rewind = 0;
    check("R4 cmd over rewind header", host_rdata, 8'h44);
    for (int i = 0; i < 4; i++) hread(d);
    hread(d); check("R3 payload 0", d, 8'hA1);
    hread(d); check("R3 payload 1", d, 8'hB2);
    hread(d); check("R3 payload 2", d, 8'hC3);
  endtask

  task automatic t_saturate();
    logic [7:0] d;
    rewind();
    for (int i = 0; i < DEPTH; i++) hwrite(8'(i) ^ 8'h5A);
    check("R5 idx at end", host_idx, DEPTH);
    check("R5 rdata at end", host_rdata, 0);
    hwrite(8'hFF);
    hread(d);
    check("R5 idx held", host_idx, DEPTH);
    rewind();
    for (int i = 0; i < DEPTH - 1; i++) hread(d);
    check("R5 last byte kept", host_rdata, 8'(DEPTH - 1) ^ 8'h5A);
  endtask

  task automatic t_media_read();
    logic [7:0] d;
    cmd(16'h0001, 8'h00, 8'h03);
    for (int i = 0; i < 4; i++) hread(d);
    for (int k = 0; k < 256; k++) hwrite(pat(9, k));
    med_xfer(1'b0, 2'd1, 9, "R6 sel1");
  endtask

  task automatic t_media_write(input logic [1:0] sel, input int seed);
    logic [7:0] d;
    cmd(16'h0200, 8'h07, 8'h0F);
    med_xfer(1'b1, sel, seed, "R7 fill");
    check("R7 idx untouched", host_idx, 0);
    hread(d); check("R2 hdr kept", d, 8'h02);
    for (int i = 0; i < 3; i++) hread(d);
    for (int k = 0; k < (128 << sel); k++) begin
      hread(d);
      if (d != pat(seed, k)) check("R7 stored payload", d, pat(seed, k));
    end
    check("R7 payload end idx", host_idx, 4 + (128 << sel));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_header();
        t_rw_rewind();
        t_saturate();
        t_media_read();
        t_media_write(2'd0, 3);
        t_media_write(2'd2, 50);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule